// File: doc/BRIEF.md
# Low-Power 8x8 Two-Pass Inverse DCT

This block turns 8x8 blocks of dequantized, already de-zigzagged frequency coefficients into 8x8 blocks of 8-bit image samples. Coefficients arrive one row per beat. Each row goes through a one-dimensional inverse transform as it enters. The row results are parked in a double-banked transpose store. Once a bank holds eight rows, a second one-dimensional transform walks it column by column. That pass adds the +128 level shift, clips the result and presents one output column per cycle. The output is flagged by a ready strobe that a downstream reader samples.

Every cosine-constant product is built from shifts and adds. No multiplier is used. An all-zero row or column leaves its operand register untouched and is replaced by a constant through a multiplexer. All registers that do not take part in a transfer are held by their own clock enables: the input operand register, the transpose banks and the output register. Because the store has two banks, a new block can stream in while the previous block's column pass runs. A steady input stream of one row per cycle therefore gives a steady output stream of one column per cycle.

Top module: `idct8x8_lp`

## Requirements
- R1: After a synchronous active-low reset, `pix_rdy` is low. No output beat appears until the eighth row of a block has been accepted, however long the input pauses before that row.
- R2: Each cycle with `in_valid` high accepts one row. Within a row, `in_coef[12k+11:12k]` is the 12-bit two's-complement coefficient of horizontal frequency k. The r-th accepted row of a block is vertical frequency r. `in_valid` may drop between rows with no loss.
- R3: A finished block leaves as 8 beats on consecutive cycles. On each beat `pix_rdy` is high and `pix_col` counts 0 to 7. `pix_out[8n+7:8n]` is the sample at row n of column `pix_col`. The first beat is registered on the third rising edge after the edge that accepts the eighth row.
- R4: Every sample is within ±1 of the value obtained by rounding the exact 2D inverse DCT (scale 1/4, weight 1/√2 on the DC terms) to the nearest integer, adding 128 and clipping to 0..255.
- R5: Results below 0 leave as 0 and results above 255 leave as 255.
- R6: A column whose eight intermediate values are all zero produces eight samples of 128 without loading the column operand register. An all-zero block therefore yields 64 samples of 128.
- R7: A row whose eight coefficients are all zero does not load the row operand register and contributes exact zeros to the transpose store.
- R8: A block's first row may follow the previous block's last row on the very next cycle. Two such blocks produce 16 beats with no idle cycle between them, and no bank is overwritten while its column pass is pending.
- R9: The transpose store changes only on cycles that write a row result. The output column and samples hold their values on cycles that produce no beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Row of coefficients present on `in_coef` |
| in_coef | input | 96 | Eight signed 12-bit coefficients of one row, frequency k at bits 12k+11:12k |
| pix_rdy | output | 1 | Output beat present |
| pix_col | output | 3 | Column index of the current beat |
| pix_out | output | 64 | Eight 8-bit samples of the column, row n at bits 8n+7:8n |

## Verification
The hardest case to reach is the handover between the two transpose banks. It happens when a new block's rows are written into one bank in the same cycles that the other bank's columns are read, and the bank that is read is still marked full when the next block's last row lands. The bench drives three blocks with no idle cycle between them. It then checks that the 24 expected columns come out in order, with the longest uninterrupted run of ready beats covering two full blocks. It also stalls a block before its last row to show that a partially filled bank never starts a column pass. A random block mix with gaps of different lengths checks the sample values against a double-precision reference.

// File: rtl/idct_pkg.sv
// Shared constants and the shift-add cosine product used by both passes.
// Assumes 13 fractional bits for the cosine weights; the shift-add recipes
// below are tied to that scale.
package idct_pkg;

    localparam int BLK    = 8;             // points per 1D transform
    localparam int IDX_W  = $clog2(BLK);   // row / column counter width
    localparam int CFRAC  = 13;            // fractional bits of cosine weights
    localparam int AW     = 40;            // accumulator width

    // Weight of input k for output n is 0.5*C(k)*cos((2n+1)k*pi/16).
    // The angle folds onto an index m in 0..8 plus a sign; the DC weight
    // 0.5/sqrt(2) equals 0.5*cos(4*pi/16), so k==0 reuses index 4.
    function automatic logic signed [AW-1:0] cterm(input logic signed [AW-1:0] v,
                                                   input int n, input int k);
        int m;
        logic neg;
        logic signed [AW-1:0] p;
        m   = ((2 * n + 1) * k) % 32;
        neg = 1'b0;
        if (m > 16) m = 32 - m;
        if (m > 8) begin
            m   = 16 - m;
            neg = 1'b1;
        end
        if (k == 0) m = 4;
        case (m)
            1: p = (v <<< 12) - (v <<< 6) - (v <<< 4) + v;                         // 4017
            2: p = (v <<< 12) - (v <<< 8) - (v <<< 6) + (v <<< 3);                 // 3784
            3: p = (v <<< 11) + (v <<< 10) + (v <<< 8) + (v <<< 6)
                 + (v <<< 3) + (v <<< 2) + (v <<< 1);                              // 3406
            4: p = (v <<< 11) + (v <<< 9) + (v <<< 8) + (v <<< 6) + (v <<< 4);     // 2896
            5: p = (v <<< 11) + (v <<< 7) + (v <<< 6) + (v <<< 5) + (v <<< 2);     // 2276
            6: p = (v <<< 10) + (v <<< 9) + (v <<< 5) - v;                         // 1567
            7: p = (v <<< 9) + (v <<< 8) + (v <<< 5) - v;                          // 799
            default: p = '0;
        endcase
        return neg ? -p : p;
    endfunction

endpackage

// File: rtl/idct_kern.sv
// Combinational 8-point 1D inverse DCT built only from shift-add products.
// Assumes signed inputs of IW bits; outputs carry CFRAC extra fraction bits.
module idct_kern
    import idct_pkg::*;
#(
    parameter int IW = 12
) (
    input  logic [BLK-1:0][IW-1:0] din,
    output logic [BLK-1:0][AW-1:0] acc
);

    logic [BLK-1:0][BLK-1:0][AW-1:0] prod;

    // One weighted term per (output, input) pair.
    for (genvar n = 0; n < BLK; n++) begin : g_out
        for (genvar k = 0; k < BLK; k++) begin : g_in
            assign prod[n][k] = cterm(AW'($signed(din[k])), n, k);
        end
    end

    // Sum the eight terms of every output point.
    always_comb begin
        for (int n = 0; n < BLK; n++) begin
            acc[n] = '0;
            for (int k = 0; k < BLK; k++) acc[n] = acc[n] + prod[n][k];
        end
    end

endmodule

// File: rtl/idct_row_stage.sv
// Row pass: registers an incoming coefficient row, transforms it and rounds
// to MW-bit intermediates with MF fraction bits. An all-zero row leaves the
// operand register untouched and is replaced by zeros at the output mux.
module idct_row_stage
    import idct_pkg::*;
#(
    parameter int IW = 12,
    parameter int MW = 16,
    parameter int MF = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [BLK-1:0][IW-1:0]  in_coef,
    output logic                    wr_en,
    output logic [BLK-1:0][MW-1:0]  wr_row
);

    localparam int RS = CFRAC - MF;
    localparam logic signed [AW-1:0] RHALF = AW'(1) <<< (RS - 1);

    logic [BLK-1:0][IW-1:0] opnd;
    logic                   rz;
    logic                   rvld;
    logic [BLK-1:0][AW-1:0] acc;

    // Input stage: enabled only by an arriving row, and only if it is nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd <= '0;
            rz   <= 1'b0;
            rvld <= 1'b0;
        end else begin
            rvld <= in_valid;
            if (in_valid) rz <= (in_coef == '0);
            if (in_valid && in_coef != '0) opnd <= in_coef;
        end
    end

    idct_kern #(.IW(IW)) i_kern (.din(opnd), .acc(acc));

    // Round to nearest and substitute zeros for a skipped row.
    always_comb begin
        for (int m = 0; m < BLK; m++)
            wr_row[m] = rz ? '0 : MW'(($signed(acc[m]) + RHALF) >>> RS);
    end

    assign wr_en = rvld;

    assert_zero_row_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rvld && rz) |-> $stable(opnd));

endmodule

// File: rtl/idct_tmem.sv
// Double-banked transpose store. Rows are written into one bank; once it
// holds BLK rows it is marked full and read out one column per cycle while
// the other bank fills. Assumes at most one row write per cycle.
module idct_tmem
    import idct_pkg::*;
#(
    parameter int MW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [BLK-1:0][MW-1:0]  wdata,
    output logic                    rd_vld,
    output logic [IDX_W-1:0]        rd_col,
    output logic [BLK-1:0][MW-1:0]  rd_data
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK - 1);

    logic [1:0][BLK-1:0][BLK-1:0][MW-1:0] mem;
    logic [1:0]       full;
    logic             wbank;
    logic             cbank;
    logic [IDX_W-1:0] wrow;
    logic [IDX_W-1:0] ccnt;

    // Store a finished row; the bank only changes when a row result exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem   <= '0;
            wrow  <= '0;
            wbank <= 1'b0;
        end else if (we) begin
            mem[wbank][wrow] <= wdata;
            wrow <= wrow + IDX_W'(1);
            if (wrow == LAST) wbank <= ~wbank;
        end
    end

    // Step the column reader through a full bank, then hand over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccnt  <= '0;
            cbank <= 1'b0;
        end else if (full[cbank]) begin
            ccnt <= ccnt + IDX_W'(1);
            if (ccnt == LAST) cbank <= ~cbank;
        end
    end

    // Bank occupancy: set by the last row write, cleared by the last column read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= '0;
        end else begin
            if (full[cbank] && ccnt == LAST) full[cbank] <= 1'b0;
            if (we && wrow == LAST) full[wbank] <= 1'b1;
        end
    end

    // Present the current column of the bank under readout.
    always_comb begin
        for (int r = 0; r < BLK; r++) rd_data[r] = mem[cbank][r][ccnt];
    end

    assign rd_vld = full[cbank];
    assign rd_col = ccnt;

    assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wrow == '0) |-> !full[wbank]);

    assert_tmem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem));

endmodule

// File: rtl/idct_col_stage.sv
// Column pass: registers one column of intermediates, transforms it, rounds,
// adds the level shift and clips to PW bits. An all-zero column skips the
// operand load and outputs the mid-level code. Output registers load only
// on beats.
module idct_col_stage
    import idct_pkg::*;
#(
    parameter int MW = 16,
    parameter int MF = 2,
    parameter int PW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cv,
    input  logic [IDX_W-1:0]        ccol,
    input  logic [BLK-1:0][MW-1:0]  cdata,
    output logic                    rdy_q,
    output logic [IDX_W-1:0]        col_q,
    output logic [BLK-1:0][PW-1:0]  pix_q
);

    localparam int CS = CFRAC + MF;
    localparam logic signed [AW-1:0] CHALF   = AW'(1) <<< (CS - 1);
    localparam logic signed [AW-1:0] PIX_OFF = AW'(1) <<< (PW - 1);
    localparam logic signed [AW-1:0] PIX_MAX = (AW'(1) <<< PW) - AW'(1);
    localparam logic [BLK-1:0][PW-1:0] MID_PIX = {BLK{PW'(1 << (PW - 1))}};

    logic [BLK-1:0][MW-1:0] opnd;
    logic                   cz;
    logic                   cvld;
    logic [IDX_W-1:0]       ccol_q;
    logic [BLK-1:0][AW-1:0] acc;
    logic [BLK-1:0][PW-1:0] pix_d;

    // Operand stage: loads only nonzero columns delivered by the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd   <= '0;
            cz     <= 1'b0;
            cvld   <= 1'b0;
            ccol_q <= '0;
        end else begin
            cvld <= cv;
            if (cv) begin
                cz     <= (cdata == '0);
                ccol_q <= ccol;
            end
            if (cv && cdata != '0) opnd <= cdata;
        end
    end

    idct_kern #(.IW(MW)) i_kern (.din(opnd), .acc(acc));

    // Round, level-shift, clip; a zero column bypasses to the mid code.
    always_comb begin
        for (int n = 0; n < BLK; n++) begin
            logic signed [AW-1:0] s;
            s = (($signed(acc[n]) + CHALF) >>> CS) + PIX_OFF;
            if (s < 0)            pix_d[n] = '0;
            else if (s > PIX_MAX) pix_d[n] = PW'(PIX_MAX);
            else                  pix_d[n] = PW'(s);
        end
    end

    // Output stage: enabled only on beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
            col_q <= '0;
            pix_q <= '0;
        end else begin
            rdy_q <= cvld;
            if (cvld) begin
                col_q <= ccol_q;
                pix_q <= cz ? MID_PIX : pix_d;
            end
        end
    end

    assert_zero_col_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cvld && cz) |-> $stable(opnd));

    assert_zero_col_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cvld && cz) |=> (pix_q == MID_PIX));

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cvld |=> ($stable(pix_q) && $stable(col_q)));

    assert_col_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_q && col_q != '0) |-> ($past(rdy_q) && $past(col_q) == col_q - IDX_W'(1)));

endmodule

// File: rtl/idct8x8_lp.sv
// Top of the 8x8 two-pass inverse DCT: row pass, double-banked transpose
// store, column pass. Assumes MID_W wide enough for the row results with
// MID_FRAC fraction bits (16 and 2 for 12-bit inputs).
module idct8x8_lp
    import idct_pkg::*;
#(
    parameter int IN_W     = 12,
    parameter int MID_W    = 16,
    parameter int MID_FRAC = 2,
    parameter int PIX_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [BLK*IN_W-1:0]    in_coef,
    output logic                   pix_rdy,
    output logic [IDX_W-1:0]       pix_col,
    output logic [BLK*PIX_W-1:0]   pix_out
);

    logic [BLK-1:0][IN_W-1:0]  coef_v;
    logic                      row_we;
    logic [BLK-1:0][MID_W-1:0] row_res;
    logic                      col_vld;
    logic [IDX_W-1:0]          col_idx;
    logic [BLK-1:0][MID_W-1:0] col_dat;
    logic [BLK-1:0][PIX_W-1:0] pix_v;

    assign coef_v  = in_coef;
    assign pix_out = pix_v;

    idct_row_stage #(.IW(IN_W), .MW(MID_W), .MF(MID_FRAC)) i_row (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(coef_v),
        .wr_en(row_we), .wr_row(row_res)
    );

    idct_tmem #(.MW(MID_W)) i_tmem (
        .clk(clk), .rst_n(rst_n), .we(row_we), .wdata(row_res),
        .rd_vld(col_vld), .rd_col(col_idx), .rd_data(col_dat)
    );

    idct_col_stage #(.MW(MID_W), .MF(MID_FRAC), .PW(PIX_W)) i_col (
        .clk(clk), .rst_n(rst_n), .cv(col_vld), .ccol(col_idx), .cdata(col_dat),
        .rdy_q(pix_rdy), .col_q(pix_col), .pix_q(pix_v)
    );

endmodule

// File: tb/test_idct8x8_lp.sv
// Scoreboard bench: the driver sends rows and queues reference columns
// computed in double precision; the monitor compares every output beat.
module test_idct8x8_lp;

    localparam int  CLK_PERIOD = 10;
    localparam int  IW = 12;
    localparam int  PW = 8;
    localparam real PI = 3.14159265358979;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [8*IW-1:0]   in_coef = '0;
    logic              pix_rdy;
    logic [2:0]        pix_col;
    logic [8*PW-1:0]   pix_out;

    idct8x8_lp i_idct8x8_lp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
        .pix_rdy(pix_rdy), .pix_col(pix_col), .pix_out(pix_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int          blk [8][8];
    logic [66:0] exp_q [$];
    string       tag_q [$];
    int          nchk = 0, nfail = 0, cyc = 0;
    int          first_cyc = 0, run = 0, max_run = 0, t_last = 0;
    logic [66:0] mon_e;
    string       mon_t;
    bit          mon_bad;
    bit          quiet;
    logic [63:0] snap;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int ref_pix(input int n, input int m);
        real a, cu, cv;
        int  r;
        a = 0.0;
        for (int v = 0; v < 8; v++)
            for (int u = 0; u < 8; u++) begin
                cu = (u == 0) ? 1.0 / $sqrt(2.0) : 1.0;
                cv = (v == 0) ? 1.0 / $sqrt(2.0) : 1.0;
                a = a + cu * cv * blk[v][u] * $cos((2 * m + 1) * u * PI / 16.0)
                                            * $cos((2 * n + 1) * v * PI / 16.0);
            end
        r = $rtoi($floor(a * 0.25 + 0.5)) + 128;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic push_exp(input string tag);
        for (int m = 0; m < 8; m++) begin
            logic [63:0] e;
            for (int n = 0; n < 8; n++) e[8*n +: 8] = 8'(ref_pix(n, m));
            exp_q.push_back({3'(m), e});
            tag_q.push_back(tag);
        end
    endtask

    // Drive one block; gap idles between rows, stall_row pauses before the last rows.
    task automatic send_block(input string tag, input int gap, input int stall_row);
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            in_valid = 1'b1;
            for (int k = 0; k < 8; k++) in_coef[IW*k +: IW] = IW'(blk[r][k]);
            if (r == 7) begin
                t_last = cyc;
                push_exp(tag);
            end
            if (r < 7) begin
                repeat (gap) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                end
            end
            if (r == stall_row) begin
                quiet = 1'b1;
                repeat (10) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    if (pix_rdy) quiet = 1'b0;
                end
                chk(quiet, "R1 partial block gave output", int'(!quiet), 0);
            end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic fill_dc(input int dc);
        for (int r = 0; r < 8; r++) for (int k = 0; k < 8; k++) blk[r][k] = 0;
        blk[0][0] = dc;
    endtask

    task automatic fill_rand(input int dc_span, input int ac_span);
        for (int r = 0; r < 8; r++)
            for (int k = 0; k < 8; k++)
                blk[r][k] = ($urandom_range(2) == 0) ?
                            int'($urandom_range(2 * ac_span)) - ac_span : 0;
        blk[0][0] = int'($urandom_range(2 * dc_span)) - dc_span;
    endtask

    // Monitor: pop and compare on every beat, track run length and first-beat time.
    always @(negedge clk) begin
        if (rst_n && pix_rdy) begin
            run++;
            if (run > max_run) max_run = run;
            if (pix_col == 3'd0) first_cyc = cyc;
            nchk++;
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL R3: unexpected beat col %0d pix %h (actual) expected no beat",
                         pix_col, pix_out);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                mon_bad = (pix_col != mon_e[66:64]);
                for (int n = 0; n < 8; n++) begin
                    int d;
                    d = int'(pix_out[8*n +: 8]) - int'(mon_e[8*n +: 8]);
                    if (d > 1 || d < -1) mon_bad = 1'b1;
                end
                if (mon_bad) begin
                    nfail++;
                    $display("FAIL %s: col %0d pix %h (actual) col %0d pix %h (expected)",
                             mon_t, pix_col, pix_out, mon_e[66:64], mon_e[63:0]);
                end
            end
        end else begin
            run = 0;
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog: run still going (actual) expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(pix_rdy == 1'b0, "R1 ready during reset", int'(pix_rdy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(pix_rdy == 1'b0, "R1 ready after reset", int'(pix_rdy), 0);

        // R6: all-zero block gives 128 everywhere
        fill_dc(0);
        send_block("R6", 0, -1);
        idle(12);

        // R3: first beat three edges after the eighth row
        fill_dc(80);
        send_block("R3", 0, -1);
        idle(12);
        chk(first_cyc == t_last + 4, "R3 latency", first_cyc - t_last, 4);

        // R1: stall before the last row, no output in between
        fill_rand(400, 60);
        send_block("R1", 0, 6);
        idle(12);

        // R2: rows with idle cycles in between
        fill_rand(500, 80);
        send_block("R2", 2, -1);
        fill_rand(300, 40);
        send_block("R2", 1, -1);
        idle(12);

        // R5: clipping at both ends
        fill_dc(2000);
        send_block("R5", 0, -1);
        fill_dc(-2000);
        send_block("R5", 0, -1);
        fill_rand(100, 60);
        blk[0][0] = 1000;
        blk[0][1] = 400;
        blk[1][0] = -400;
        send_block("R5", 0, -1);
        idle(12);

        // R7: several all-zero rows inside a block
        fill_rand(600, 90);
        for (int k = 0; k < 8; k++) begin
            blk[1][k] = 0;
            blk[2][k] = 0;
            blk[5][k] = 0;
            blk[7][k] = 0;
        end
        send_block("R7", 0, -1);
        idle(12);

        // R8: three blocks back to back, output must not break
        max_run = 0;
        for (int b = 0; b < 3; b++) begin
            fill_rand(600, 100);
            send_block("R8", 0, -1);
        end
        idle(30);
        chk(max_run >= 16, "R8 gapless output run", max_run, 16);

        // R9: output holds while idle
        snap = pix_out;
        idle(5);
        chk(pix_out == snap, "R9 output changed while idle", int'(pix_out != snap), 0);

        // R4: random mix with varied gaps
        for (int b = 0; b < 10; b++) begin
            fill_rand(700, 120);
            send_block("R4", b % 3, -1);
        end
        idle(30);
        chk(exp_q.size() == 0, "R3 missing beats", exp_q.size(), 0);
        finish_run();
    end

endmodule